// File: doc/BRIEF.md
# Programmable Bus Clock Divider with Sleep Park

This block derives a slower bus clock for an attached communications processor from the host bus clock. A two-bit ratio input selects division by 1, 2, 3 or 4. Every ratio gives a 50% duty cycle, and the odd ratio of three uses both edges of the source clock to get it. Each output period starts with a rising output edge that lines up with a rising source edge. The block samples ratio and sleep requests only at that boundary, so the output never shows a shortened pulse.

A sleep input parks the output at a steady high level, and the attached processor then stops and saves power. Parking starts at a period boundary, after the low phase in progress has finished. When sleep is released, the output stays high and a fresh period begins at the next rising source edge. Inside the block a small state machine tracks the position in the period. Its states are BOOT, RUN and PARK, and the names below are used for its transitions:
- BOOT→RUN is the first edge after reset.
- RUN→RUN is either a count step or a reload at the boundary.
- RUN→PARK happens at the boundary with sleep asserted.
- PARK→PARK holds while sleep is asserted.
- PARK→RUN is the resume.

Top module: `busclk_divider`

## Requirements
- R1: Ratio code 00 divides the source clock by 1, 01 by 2, 10 by 3 and 11 by 4. The output period is N source cycles for a divide value of N.
- R2: In every ratio, including divide-by-3, the output is high for exactly N of the 2N source half-cycles of a period. The high phase comes first and begins at a rising source edge.
- R3: While rst_ni is low the output is low. The ratio held inside the block resets to code 01. The first output period after reset release is a divide-by-2 period that starts high at the first rising source edge, whatever ratio_i and sleep_i are.
- R4: ratio_i is sampled only at the rising source edge that starts a new output period. A change in the middle of a period does not alter that period.
- R5: With sleep_i high at a period boundary, the output is held steady high from that boundary for as long as sleep_i stays high.
- R6: A sleep_i pulse that rises and falls within one output period has no effect on the output.
- R7: When sleep_i is low at a rising source edge during the park, a new period starts there with ratio_i sampled at that edge. The output does not fall before that period's normal low phase.
- R8: A sleep request made in the middle of a period lets that period's remaining high and low phases complete before the output is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host bus source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | RATIO_W (2) | Divide select: 00=/1, 01=/2, 10=/3, 11=/4 |
| sleep_i | input | 1 | Park the output high while set |
| busclk_o | output | 1 | Divided bus clock |

## Verification
The hardest case to reach is a request that arrives off the boundary while the divide-by-3 or divide-by-4 count is in progress. This covers a ratio change in the middle of a period, a sleep request that lands partway through, and a sleep pulse that opens and closes inside a single period. The stimulus reaches these cases by first aligning to a known period start after the divide-by-2 boot period. It then counts source cycles and flips the inputs in the low half of a chosen cycle. The bench samples both halves of every cycle, so a period that is too short, a runt pulse or an early park all show up as a wrong half-cycle value.

// File: rtl/busclk_div_pkg.sv
`timescale 1ns/1ps
package busclk_div_pkg;

    // Sequencer states of the divider
    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,   // held in reset, output low
        ST_RUN  = 2'd1,   // counting through an output period
        ST_PARK = 2'd2    // sleep: output parked high
    } div_state_e;

endpackage

// File: rtl/busclk_div_fsm.sv
`timescale 1ns/1ps
module busclk_div_fsm
    import busclk_div_pkg::*;
#(
    parameter int RATIO_W     = 2,
    parameter int RESET_RATIO = 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               sleep_i,
    output div_state_e         st_q,
    output logic [RATIO_W-1:0] cnt_q,
    output logic [RATIO_W-1:0] div_q,
    output div_state_e         st_d,
    output logic [RATIO_W-1:0] cnt_d,
    output logic [RATIO_W-1:0] div_d
);

    localparam logic [RATIO_W-1:0] BOOT_DIV = RATIO_W'(RESET_RATIO);

    logic at_boundary;
    assign at_boundary = (cnt_q == div_q);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= ST_BOOT;
            cnt_q <= '0;
            div_q <= BOOT_DIV;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            div_q <= div_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        div_d = div_q;
        unique case (st_q)
            ST_BOOT: begin
                st_d  = ST_RUN;
                cnt_d = '0;
                div_d = BOOT_DIV;
            end
            ST_RUN: begin
                if (!at_boundary) begin
                    cnt_d = cnt_q + RATIO_W'(1);
                end else if (sleep_i) begin
                    st_d  = ST_PARK;
                    cnt_d = '0;
                end else begin
                    cnt_d = '0;
                    div_d = ratio_i;
                end
            end
            ST_PARK: begin
                if (!sleep_i) begin
                    st_d  = ST_RUN;
                    cnt_d = '0;
                    div_d = ratio_i;
                end
            end
            default: begin
                st_d  = ST_BOOT;
                cnt_d = '0;
                div_d = BOOT_DIV;
            end
        endcase
    end

    // R1: the count never runs past the held divide value
    a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_RUN) |-> (cnt_q <= div_q));

    // R4: held ratio is stable inside a period
    a_r4_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_RUN && cnt_q != '0) |-> $stable(div_q));

    // R8: parking only begins from the last cycle of a period
    a_r8_park_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_PARK && $past(st_q) == ST_RUN) |-> $past(cnt_q == div_q));

    // R3: boot lasts exactly one cycle after reset release
    a_r3_boot_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_BOOT) |=> (st_q == ST_RUN && div_q == BOOT_DIV));

endmodule

// File: rtl/busclk_div_slots.sv
`timescale 1ns/1ps
module busclk_div_slots
    import busclk_div_pkg::*;
#(
    parameter int RATIO_W = 2
) (
    input  div_state_e         st,
    input  logic [RATIO_W-1:0] cnt,
    input  logic [RATIO_W-1:0] div,
    output logic               hi_first,
    output logic               hi_second
);

    localparam int HW = RATIO_W + 2;

    logic [HW-1:0] half_idx;
    logic [HW-1:0] span;

    // Half-slot index inside the period against the period length N
    assign half_idx = {1'b0, cnt, 1'b0};
    assign span     = HW'(div) + HW'(1);

    always_comb begin
        unique case (st)
            ST_RUN: begin
                hi_first  = (half_idx < span);
                hi_second = ((half_idx + HW'(1)) < span);
            end
            ST_PARK: begin
                hi_first  = 1'b1;
                hi_second = 1'b1;
            end
            default: begin
                hi_first  = 1'b0;
                hi_second = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/busclk_divider.sv
`timescale 1ns/1ps
module busclk_divider
    import busclk_div_pkg::*;
#(
    parameter int RATIO_W     = 2,
    parameter int RESET_RATIO = 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               sleep_i,
    output logic               busclk_o
);

    div_state_e         st_q, st_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d, div_q, div_d;
    logic               hi_first_d, hi_second_d;
    logic               first_q, second_q;

    busclk_div_fsm #(
        .RATIO_W     (RATIO_W),
        .RESET_RATIO (RESET_RATIO)
    ) u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ratio_i (ratio_i),
        .sleep_i (sleep_i),
        .st_q    (st_q),
        .cnt_q   (cnt_q),
        .div_q   (div_q),
        .st_d    (st_d),
        .cnt_d   (cnt_d),
        .div_d   (div_d)
    );

    busclk_div_slots #(
        .RATIO_W (RATIO_W)
    ) u_slots (
        .st        (st_d),
        .cnt       (cnt_d),
        .div       (div_d),
        .hi_first  (hi_first_d),
        .hi_second (hi_second_d)
    );

    // Output register: per-cycle level for each source half-cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            first_q  <= 1'b0;
            second_q <= 1'b0;
        end else begin
            first_q  <= hi_first_d;
            second_q <= hi_second_d;
        end
    end

    // Half-cycle select: high half of source uses first slot
    assign busclk_o = clk_i ? first_q : second_q;

    // R5: while parked both half-slots are high
    a_r5_park_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_PARK) |-> (first_q && second_q));

    // R7: leaving the park starts a fresh high phase
    a_r7_resume_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_q) == ST_PARK && st_q == ST_RUN) |-> (first_q && cnt_q == '0));

    // R2: a period always opens with a high first half
    a_r2_period_opens_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_RUN && cnt_q == '0) |-> first_q);

endmodule

// File: tb/busclk_divider_tb.sv
`timescale 1ns/1ps
module busclk_divider_tb;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [1:0] ratio_i = 2'b00;
    logic       sleep_i = 1'b0;
    logic       busclk_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk_i = ~clk_i;

    busclk_divider u_dut (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ratio_i  (ratio_i),
        .sleep_i  (sleep_i),
        .busclk_o (busclk_o)
    );

    task automatic check_bit(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    // Check ncyc source cycles of a divide-by-n period starting at phase k0.
    // Returns at posedge+7 of the last cycle (inside its low half).
    task automatic check_cycles(input int n, input int ncyc, input int k0, input string req);
        for (int i = 0; i < ncyc; i++) begin
            int k;
            k = (k0 + i) % n;
            @(posedge clk_i);
            #2;
            check_bit(busclk_o, logic'((2 * k) < n), req, $sformatf("div%0d cycle%0d high-half", n, k));
            #5;
            check_bit(busclk_o, logic'((2 * k + 1) < n), req, $sformatf("div%0d cycle%0d low-half", n, k));
        end
    endtask

    task automatic check_parked(input int ncyc, input string req);
        for (int i = 0; i < ncyc; i++) begin
            @(posedge clk_i);
            #2;
            check_bit(busclk_o, 1'b1, req, "parked high-half");
            #5;
            check_bit(busclk_o, 1'b1, req, "parked low-half");
        end
    endtask

    // Reset with given inputs, check low output, release; the boot div-2
    // period is checked too (R3).
    task automatic do_reset(input logic [1:0] r, input logic s);
        @(posedge clk_i);
        #1;
        rst_ni  = 1'b0;
        ratio_i = r;
        sleep_i = s;
        @(posedge clk_i);
        #2;
        check_bit(busclk_o, 1'b0, "R3", "reset high-half");
        #5;
        check_bit(busclk_o, 1'b0, "R3", "reset low-half");
        rst_ni = 1'b1;
        check_cycles(2, 2, 0, "R3");
    endtask

    task automatic test_each_ratio();
        for (int r = 0; r < 4; r++) begin
            do_reset(2'(r), 1'b0);
            check_cycles(r + 1, 3 * (r + 1), 0, (r == 2) ? "R2" : "R1");
        end
    endtask

    task automatic test_ratio_change();
        do_reset(2'b11, 1'b0);
        check_cycles(4, 2, 0, "R4");
        ratio_i = 2'b00;                 // mid-period change
        check_cycles(4, 2, 2, "R4");
        check_cycles(1, 4, 0, "R4");
        ratio_i = 2'b10;                 // every div1 cycle is a boundary
        check_cycles(3, 6, 0, "R4");
    endtask

    task automatic test_sleep_entry();
        do_reset(2'b10, 1'b0);
        check_cycles(3, 1, 0, "R8");
        sleep_i = 1'b1;
        check_cycles(3, 2, 1, "R8");
        check_parked(6, "R5");
        ratio_i = 2'b01;
        check_parked(2, "R5");
        sleep_i = 1'b0;
        check_cycles(2, 4, 0, "R7");
    endtask

    task automatic test_short_pulse();
        do_reset(2'b11, 1'b0);
        check_cycles(4, 1, 0, "R6");
        sleep_i = 1'b1;
        check_cycles(4, 1, 1, "R6");
        sleep_i = 1'b0;
        check_cycles(4, 2, 2, "R6");
        check_cycles(4, 4, 0, "R6");
    endtask

    task automatic test_sleep_at_boot();
        do_reset(2'b01, 1'b1);
        check_parked(4, "R5");
        ratio_i = 2'b11;
        sleep_i = 1'b0;
        check_cycles(4, 8, 0, "R7");
    endtask

    task automatic test_sleep_div1();
        do_reset(2'b00, 1'b0);
        check_cycles(1, 2, 0, "R1");
        sleep_i = 1'b1;
        check_parked(3, "R5");
        sleep_i = 1'b0;
        check_cycles(1, 3, 0, "R7");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        test_each_ratio();
        test_ratio_change();
        test_sleep_entry();
        test_short_pulse();
        test_sleep_at_boot();
        test_sleep_div1();
        finish_run();
    end

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

endmodule